// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns two incremental-encoder phase lines and an index line into an unsigned position count, a direction flag and a velocity measurement. The lines can be read as a quadrature pair or as a count clock with a direction level. Each physical line can be inverted, and the pair can be exchanged. The position either wraps between zero and a programmed ceiling or runs freely and is cleared by the index mark.

Every edge that moves the position is also fed to a power-of-two predivider. While velocity capture is on, a window timer counts the divided pulses over a programmable number of clock cycles. At the end of each window it publishes the total. The decoder stays inert until it is switched on, and once on only the block reset switches it off again.

Top module: `quad_pos_decoder`

## Requirements
- R1: After reset, `position` is 0, `dir_rev` is 0, `enabled` is 0, `vel_value` is 0 and `vel_valid` is 0.
- R2: `enabled` goes high one cycle after `en_set` is seen high and stays high whatever `en_set` does later. While `enabled` is low, the position and the direction flag ignore all input edges.
- R3: Each line passes through two synchronising flops. A change of `enc_a` applied before rising edge k shows on `position` after rising edge k+2 and not before.
- R4: In quadrature mode (`cfg_clkdir`=0) with `cfg_both_edges`=0, each single edge of effective phase A counts. It counts +1 if A differs from B after the edge and -1 otherwise. Edges of B are not counted.
- R5: With `cfg_both_edges`=1 in quadrature mode, single edges of B also count: +1 if A equals B after the edge and -1 otherwise.
- R6: `dir_rev` holds 1 when the latest valid edge indicated reverse travel and 0 when it indicated forward travel. In quadrature mode, B edges update it even when they are not counted. A cycle in which both phases change is ignored.
- R7: In clock/direction mode (`cfg_clkdir`=1), only rising edges of effective A count. The count is -1 when effective B is 1 and +1 when it is 0. `cfg_both_edges` has no effect, and B changes alone never count.
- R8: The effective phases are formed by first inverting each physical line by its own invert bit and then, when `cfg_swap`=1, exchanging the two results.
- R9: With `cfg_idx_reset`=0, counting up from a value at or above `max_pos` gives 0, and counting down from 0 gives `max_pos`. The index line is ignored in this mode.
- R10: With `cfg_idx_reset`=1, a rising edge of the synchronised index clears the position. Otherwise the count wraps at the full width of `position`.
- R11: Counted edges feed a predivider that emits one pulse per 2^`cfg_vel_div` counted edges (codes 0 to 7 give 1 to 128). The predivider is cleared while capture is off.
- R12: While `cfg_vel_en` and `enabled` are both high, every `win_len` cycles `vel_valid` pulses for one cycle and `vel_value` takes the number of divided pulses in that window. The next window then starts from zero. With capture off, `vel_valid` stays low and `vel_value` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_set | input | 1 | Sets the sticky enable |
| cfg_swap | input | 1 | Exchange the phases after inversion |
| cfg_inv_a | input | 1 | Invert physical line A |
| cfg_inv_b | input | 1 | Invert physical line B |
| cfg_clkdir | input | 1 | 1: A is count clock, B is direction |
| cfg_both_edges | input | 1 | 1: count edges of both phases |
| cfg_idx_reset | input | 1 | 1: index clears, 0: wrap at max_pos |
| cfg_vel_en | input | 1 | Velocity capture on |
| cfg_vel_div | input | DIV_W | Predivide code, divide by 2^code |
| max_pos | input | POS_W | Position ceiling for wrap mode |
| win_len | input | WIN_W | Velocity window length in cycles |
| enc_a | input | 1 | Physical phase line A |
| enc_b | input | 1 | Physical phase line B |
| enc_idx | input | 1 | Index mark |
| position | output | POS_W | Position count |
| dir_rev | output | 1 | 1 when travel is in reverse |
| enabled | output | 1 | Sticky enable state |
| vel_value | output | VEL_W | Last completed window count |
| vel_valid | output | 1 | One-cycle pulse at window end |

## Verification
The bench builds the block with an 8-bit position, so a free-running count crosses from 0 to 255 in a couple of steps and the full-width wrap of index mode can be observed. An 8-bit velocity value and a 10-bit window give windows of 300 cycles. These are long enough to hold a burst of a dozen or more encoder steps followed by an empty window. Setting the ceiling to 10 makes the wrap in both directions reachable with a handful of steps.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

    typedef struct packed {
        logic swap;
        logic inv_a;
        logic inv_b;
        logic clkdir;
        logic both_edges;
    } qpd_phase_cfg_t;

endpackage

// File: rtl/qpd_sync.sv
module qpd_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/qpd_edge.sv
module qpd_edge
    import qpd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  qpd_phase_cfg_t cfg,
    input  logic           a_s,
    input  logic           b_s,
    input  logic           idx_s,
    output logic           cnt,
    output logic           rev,
    output logic           dir_rev,
    output logic           idx_rise
);
    typedef struct packed {
        logic pa;
        logic pb;
        logic pi;
        logic dir;
    } edge_t;

    edge_t st_d, st_q;
    logic a0, b0, ea, eb, a_chg, b_chg, upd;

    always_comb begin
        a0    = a_s ^ cfg.inv_a;
        b0    = b_s ^ cfg.inv_b;
        ea    = cfg.swap ? b0 : a0;
        eb    = cfg.swap ? a0 : b0;
        a_chg = ea ^ st_q.pa;
        b_chg = eb ^ st_q.pb;
        cnt   = 1'b0;
        rev   = 1'b0;
        upd   = 1'b0;
        if (cfg.clkdir) begin
            if (a_chg && ea) begin
                cnt = 1'b1;
                rev = eb;
                upd = 1'b1;
            end
        end else if (a_chg && !b_chg) begin
            cnt = 1'b1;
            rev = ~(ea ^ eb);
            upd = 1'b1;
        end else if (b_chg && !a_chg) begin
            cnt = cfg.both_edges;
            rev = ea ^ eb;
            upd = 1'b1;
        end
        cnt      = cnt & en;
        idx_rise = idx_s & ~st_q.pi;
        st_d.pa  = ea;
        st_d.pb  = eb;
        st_d.pi  = idx_s;
        st_d.dir = (en && upd) ? rev : st_q.dir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_rev = st_q.dir;

    // R6: a cycle where both phases move is never counted
    a_r6_double_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.clkdir && a_chg && b_chg) |-> !cnt);
endmodule

// File: rtl/qpd_pos.sv
module qpd_pos #(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cnt,
    input  logic             rev,
    input  logic             idx_rise,
    input  logic             idx_mode,
    input  logic [POS_W-1:0] max_pos,
    output logic [POS_W-1:0] pos
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
    } pos_t;

    pos_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (idx_mode && idx_rise) begin
                st_d.pos = '0;
            end else if (cnt) begin
                if (rev) begin
                    if (!idx_mode && st_q.pos == '0) st_d.pos = max_pos;
                    else                             st_d.pos = st_q.pos - POS_W'(1);
                end else begin
                    if (!idx_mode && st_q.pos >= max_pos) st_d.pos = '0;
                    else                                  st_d.pos = st_q.pos + POS_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos = st_q.pos;

    a_r9_stays_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_mode && st_q.pos <= max_pos) |=> (st_q.pos <= $past(max_pos)));

    a_r2_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.pos));

    a_r10_index_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (en && idx_mode && idx_rise) |=> (st_q.pos == '0));
endmodule

// File: rtl/qpd_vel.sv
module qpd_vel #(
    parameter int VEL_W = 16,
    parameter int WIN_W = 16,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pulse,
    input  logic [DIV_W-1:0] div_code,
    input  logic [WIN_W-1:0] win_len,
    output logic [VEL_W-1:0] vel,
    output logic             valid
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [VEL_W-1:0] acc;
        logic [WIN_W-1:0] tmr;
        logic [VEL_W-1:0] vel;
        logic             valid;
    } vel_t;

    vel_t st_d, st_q;
    logic [PRE_W:0]   span;
    logic [PRE_W:0]   lim_full;
    logic [PRE_W-1:0] lim;
    logic             ppulse, last;
    logic [VEL_W-1:0] acc_sum;

    always_comb begin
        span     = (PRE_W + 1)'(1) << div_code;
        lim_full = span - (PRE_W + 1)'(1);
        lim      = lim_full[PRE_W-1:0];
        ppulse   = run && pulse && (st_q.pre == lim);
        acc_sum  = st_q.acc + {{(VEL_W-1){1'b0}}, ppulse};
        last     = (win_len <= WIN_W'(1)) || (st_q.tmr >= win_len - WIN_W'(1));
        st_d     = st_q;
        st_d.valid = 1'b0;
        if (!run) begin
            st_d.pre = '0;
            st_d.acc = '0;
            st_d.tmr = '0;
        end else begin
            if (pulse) st_d.pre = (st_q.pre == lim) ? '0 : st_q.pre + PRE_W'(1);
            if (last) begin
                st_d.vel   = acc_sum;
                st_d.valid = 1'b1;
                st_d.acc   = '0;
                st_d.tmr   = '0;
            end else begin
                st_d.acc = acc_sum;
                st_d.tmr = st_q.tmr + WIN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vel   = st_q.vel;
    assign valid = st_q.valid;

    a_r12_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !st_q.valid);

    a_r12_value_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> $stable(st_q.vel));
endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder
    import qpd_pkg::*;
#(
    parameter int POS_W = 16,
    parameter int VEL_W = 16,
    parameter int WIN_W = 16,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             cfg_swap,
    input  logic             cfg_inv_a,
    input  logic             cfg_inv_b,
    input  logic             cfg_clkdir,
    input  logic             cfg_both_edges,
    input  logic             cfg_idx_reset,
    input  logic             cfg_vel_en,
    input  logic [DIV_W-1:0] cfg_vel_div,
    input  logic [POS_W-1:0] max_pos,
    input  logic [WIN_W-1:0] win_len,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    output logic [POS_W-1:0] position,
    output logic             dir_rev,
    output logic             enabled,
    output logic [VEL_W-1:0] vel_value,
    output logic             vel_valid
);
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] lines_s;
    logic               en_d, en_q;
    logic               cnt, rev, idx_rise;
    qpd_phase_cfg_t     pcfg;

    always_comb begin
        en_d            = en_q | en_set;
        pcfg.swap       = cfg_swap;
        pcfg.inv_a      = cfg_inv_a;
        pcfg.inv_b      = cfg_inv_b;
        pcfg.clkdir     = cfg_clkdir;
        pcfg.both_edges = cfg_both_edges;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    qpd_sync #(.W(N_LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({enc_idx, enc_b, enc_a}),
        .dout (lines_s)
    );

    qpd_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .cfg     (pcfg),
        .a_s     (lines_s[0]),
        .b_s     (lines_s[1]),
        .idx_s   (lines_s[2]),
        .cnt     (cnt),
        .rev     (rev),
        .dir_rev (dir_rev),
        .idx_rise(idx_rise)
    );

    qpd_pos #(.POS_W(POS_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .cnt     (cnt),
        .rev     (rev),
        .idx_rise(idx_rise),
        .idx_mode(cfg_idx_reset),
        .max_pos (max_pos),
        .pos     (position)
    );

    qpd_vel #(.VEL_W(VEL_W), .WIN_W(WIN_W), .DIV_W(DIV_W)) u_vel (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cfg_vel_en && en_q),
        .pulse   (cnt),
        .div_code(cfg_vel_div),
        .win_len (win_len),
        .vel     (vel_value),
        .valid   (vel_valid)
    );

    assign enabled = en_q;

    a_r2_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);
endmodule

// File: tb/sim_quad_pos_decoder.sv
module sim_quad_pos_decoder;
    localparam int POS_W = 8;
    localparam int VEL_W = 8;
    localparam int WIN_W = 10;
    localparam int DIV_W = 3;
    localparam int MASK  = (1 << POS_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_set = 1'b0;
    logic c_swap = 1'b0, c_inv_a = 1'b0, c_inv_b = 1'b0;
    logic c_clkdir = 1'b0, c_both = 1'b0, c_idx = 1'b0, c_vel_en = 1'b0;
    logic [DIV_W-1:0] c_div = '0;
    logic [POS_W-1:0] c_max = POS_W'(10);
    logic [WIN_W-1:0] c_win = WIN_W'(300);
    logic ra = 1'b0, rb = 1'b0, ri = 1'b0;
    logic [POS_W-1:0] position;
    logic dir_rev, enabled, vel_valid;
    logic [VEL_W-1:0] vel_value;

    always #5 clk = ~clk;

    quad_pos_decoder #(.POS_W(POS_W), .VEL_W(VEL_W), .WIN_W(WIN_W), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .en_set(en_set),
        .cfg_swap(c_swap), .cfg_inv_a(c_inv_a), .cfg_inv_b(c_inv_b),
        .cfg_clkdir(c_clkdir), .cfg_both_edges(c_both), .cfg_idx_reset(c_idx),
        .cfg_vel_en(c_vel_en), .cfg_vel_div(c_div), .max_pos(c_max), .win_len(c_win),
        .enc_a(ra), .enc_b(rb), .enc_idx(ri),
        .position(position), .dir_rev(dir_rev), .enabled(enabled),
        .vel_value(vel_value), .vel_valid(vel_valid)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string cur  = "R1";

    int    pos_exp[$];
    string pos_tag[$];
    int    vel_exp[$];
    string vel_tag[$];

    int   m_pos = 0;
    logic m_dir = 1'b0, m_en = 1'b0, m_ea = 1'b0, m_eb = 1'b0;
    int   ph = 0;
    int   last_pos = 0;

    task automatic check(string req, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // reference model of the requirements, run after every pin or config change
    task automatic model_update();
        logic a0, b0, ea, eb, ac, bc, cnt, rev, upd;
        int np;
        a0 = ra ^ c_inv_a;
        b0 = rb ^ c_inv_b;
        ea = c_swap ? b0 : a0;
        eb = c_swap ? a0 : b0;
        ac = ea ^ m_ea;
        bc = eb ^ m_eb;
        cnt = 0; rev = 0; upd = 0;
        if (c_clkdir) begin
            if (ac && ea) begin cnt = 1; rev = eb; upd = 1; end
        end else if (ac && !bc) begin
            cnt = 1; rev = (ea == eb); upd = 1;
        end else if (bc && !ac) begin
            cnt = c_both; rev = (ea != eb); upd = 1;
        end
        if (m_en) begin
            if (upd) m_dir = rev;
            if (cnt) begin
                if (rev) np = (!c_idx && m_pos == 0) ? int'(c_max) : ((m_pos - 1) & MASK);
                else     np = (!c_idx && m_pos >= int'(c_max)) ? 0 : ((m_pos + 1) & MASK);
                if (np != m_pos) begin
                    pos_exp.push_back(np);
                    pos_tag.push_back(cur);
                end
                m_pos = np;
            end
        end
        m_ea = ea;
        m_eb = eb;
    endtask

    task automatic settle();
        model_update();
        repeat (6) @(negedge clk);
    endtask

    task automatic qstep(int d);
        ph = (ph + d) & 3;
        ra = (ph == 1 || ph == 2);
        rb = (ph == 2 || ph == 3);
        settle();
    endtask

    task automatic clk_pulse();
        ra = 1'b1; settle();
        ra = 1'b0; settle();
    endtask

    task automatic idx_pulse();
        ri = 1'b1;
        if (m_en && c_idx && m_pos != 0) begin
            pos_exp.push_back(0);
            pos_tag.push_back(cur);
            m_pos = 0;
        end
        repeat (6) @(negedge clk);
        ri = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // position monitor: every change of the output must match the next expected value
    always @(negedge clk) begin
        if (rst_n && int'(position) != last_pos) begin
            n_tests++;
            if (pos_exp.size() == 0) begin
                n_fail++;
                $display("FAIL %s: got %0d expected no position change", cur, position);
            end else begin
                int e;
                string t;
                e = pos_exp.pop_front();
                t = pos_tag.pop_front();
                if (int'(position) != e) begin
                    n_fail++;
                    $display("FAIL %s: got %0d expected %0d", t, position, e);
                end
            end
            last_pos = int'(position);
        end
    end

    // velocity monitor: each window result is compared with the queued value
    always @(negedge clk) begin
        if (rst_n && vel_valid) begin
            n_tests++;
            if (vel_exp.size() == 0) begin
                n_fail++;
                $display("FAIL R12: got valid with %0d expected no window result", vel_value);
            end else begin
                int e;
                string t;
                e = vel_exp.pop_front();
                t = vel_tag.pop_front();
                if (int'(vel_value) != e) begin
                    n_fail++;
                    $display("FAIL %s: got %0d expected %0d", t, vel_value, e);
                end
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int p;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur = "R1";
        check("R1", position, 0);
        check("R1", dir_rev, 0);
        check("R1", enabled, 0);
        check("R1", vel_value, 0);
        check("R1", vel_valid, 0);

        cur = "R2";
        qstep(1); qstep(1);
        check("R2", position, 0);
        check("R2", pos_exp.size(), 0);
        en_set = 1'b1; m_en = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        repeat (4) @(negedge clk);
        check("R2", enabled, 1);

        // R3: A falls with B high, a forward step; two edges of delay then the update
        cur = "R3";
        ph = 3; ra = 1'b0; rb = 1'b1;
        model_update();
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R3", position, 0);
        @(posedge clk); @(negedge clk);
        check("R3", position, 1);
        repeat (4) @(negedge clk);

        cur = "R4";
        repeat (4) qstep(1);
        check("R4", position, 3);
        check("R4", dir_rev, 0);
        cur = "R6";
        qstep(-1);
        check("R6", position, 2);
        check("R6", dir_rev, 1);
        qstep(-1);
        check("R4", position, 2);
        check("R6", dir_rev, 1);
        qstep(1);
        check("R4", position, 2);
        check("R6", dir_rev, 0);
        ra = 1'b0; rb = 1'b0; ph = 0;
        settle();
        check("R6", position, 2);
        check("R6", dir_rev, 0);

        cur = "R5";
        c_both = 1'b1;
        settle();
        repeat (4) qstep(1);
        check("R5", position, 6);

        cur = "R9";
        repeat (5) qstep(1);
        check("R9", position, 0);
        qstep(-1);
        check("R9", position, 10);
        qstep(1);
        check("R9", position, 0);

        cur = "R8";
        c_inv_a = 1'b1;
        settle();
        qstep(1);
        check("R8", dir_rev, 1);
        c_inv_a = 1'b0;
        settle();

        cur = "R10";
        c_idx = 1'b1;
        settle();
        idx_pulse();
        check("R10", position, 0);

        cur = "R7";
        c_clkdir = 1'b1;
        settle();
        ra = 1'b0; rb = 1'b0;
        settle();
        idx_pulse();
        repeat (3) clk_pulse();
        check("R7", position, 3);
        check("R7", dir_rev, 0);
        rb = 1'b1;
        settle();
        check("R7", position, 3);
        repeat (5) clk_pulse();
        check("R10", position, 254);
        check("R7", dir_rev, 1);

        cur = "R8";
        rb = 1'b0;
        settle();
        c_inv_a = 1'b1; c_swap = 1'b1;
        settle();
        p = int'(position);
        rb = 1'b1; settle(); rb = 1'b0; settle();
        rb = 1'b1; settle(); rb = 1'b0; settle();
        check("R8", position, (p - 2) & MASK);
        p = int'(position);
        ra = 1'b1; settle(); ra = 1'b0; settle();
        check("R8", position, p);
        c_inv_a = 1'b0; c_swap = 1'b0;
        settle();
        c_clkdir = 1'b0;
        settle();
        ph = 0;

        cur = "R9";
        c_idx = 1'b0; c_max = '1;
        settle();
        qstep(1);
        p = int'(position);
        idx_pulse();
        check("R9", position, p);

        cur = "R11";
        c_div = 3'd0; c_vel_en = 1'b1;
        vel_exp.push_back(16); vel_tag.push_back("R11");
        repeat (16) qstep(1);
        wait (vel_exp.size() == 0);
        @(negedge clk);
        c_vel_en = 1'b0;
        @(negedge clk);
        check("R12", vel_value, 16);
        cur = "R12";
        repeat (4) qstep(1);
        repeat (350) @(negedge clk);
        check("R12", vel_value, 16);

        cur = "R11";
        c_div = 3'd2; c_vel_en = 1'b1;
        vel_exp.push_back(3); vel_tag.push_back("R11");
        vel_exp.push_back(0); vel_tag.push_back("R12");
        repeat (15) qstep(1);
        wait (vel_exp.size() == 0);
        @(negedge clk);
        c_vel_en = 1'b0;
        repeat (4) @(negedge clk);

        c_div = 3'd3; c_vel_en = 1'b1;
        vel_exp.push_back(1); vel_tag.push_back("R11");
        repeat (14) qstep(1);
        wait (vel_exp.size() == 0);
        @(negedge clk);
        c_vel_en = 1'b0;
        repeat (10) @(negedge clk);

        check("R4", pos_exp.size(), 0);
        check("R12", vel_exp.size(), 0);
        summary();
    end
endmodule